// File: doc/BRIEF.md
# NAND Page Read Pointer Controller

This block is the device-side read path of a small-page NAND memory model. A host drives command and address bytes on a byte-wide bus. A command-latch strobe, an address-latch strobe, an active-low write strobe, an active-low read strobe and an active-low chip enable qualify each byte. All of them are sampled on the block clock. A write byte is taken when the write strobe rises. An output byte is produced for each falling edge of the read strobe.

The block keeps an area pointer. The pointer selects either the 512-byte main region or the 16-byte spare tail of each 528-byte page. After a full address has been given, the ready output goes low for a fixed load time while the page is fetched. Bytes then stream from the chosen column to the end of the page. After the last column the block moves to the next page, waits the load time again and keeps streaming. Raising chip enable ends the stream.

The array is a synchronous read port whose contents are a fixed function of the page and column. A host or bench can therefore predict every byte without a programming path.

Top module: `nand_rdptr_ctrl`

## Requirements
- R1: After reset, `rb_n` is 1 and `io_out` is 0. Read-strobe falls before any address has been given leave `io_out` unchanged.
- R2: A completed address sequence drives `rb_n` low for exactly `TR_CYCLES` clocks, then `rb_n` returns high. The sequence is three address-latch writes: column byte, page low byte, page high byte. `rb_n` never stays low longer than `TR_CYCLES`.
- R3: In main mode (command 00h), the first byte out is at the given column. Each later read-strobe fall gives the next column. The byte at page p, column c is `c[7:0] ^ {p[5:0], c[9:8]}`.
- R4: Command 01h selects main mode with the start column at 256 plus the column byte.
- R5: Command 50h selects spare mode. The start column is 512 plus bits 3:0 of the column byte, and bits 7:4 have no effect.
- R6: After the byte at column 527 has been output, the page number steps by one, wrapping modulo 2^`PAGE_AW`. `rb_n` then goes low for `TR_CYCLES`, and streaming resumes at column 0 in main mode or column 512 in spare mode.
- R7: With `ce_n` high, a stream ends and any load in progress is aborted. `rb_n` goes high, and read-strobe falls leave `io_out` unchanged, including after `ce_n` returns low.
- R8: The mode persists. A new address sequence without a new command reuses the last mode, and spare mode stays selected until command 00h or 01h is written.
- R9: While `rb_n` is low, read-strobe falls leave `io_out` unchanged.
- R10: Command codes other than 00h, 01h and 50h leave the area pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| we_n | input | 1 | Write strobe, byte taken on rising edge |
| re_n | input | 1 | Read strobe, byte produced per falling edge |
| io_in | input | 8 | Command and address byte |
| io_out | output | 8 | Read data byte |
| rb_n | output | 1 | Ready (1) or busy loading a page (0) |

## Verification
The bench builds the block with `TR_CYCLES` = 6 and `PAGE_AW` = 2. The short load time lets every busy window be counted to the clock. The four-page array makes the page-number wrap reachable with a few hundred read strobes. Spare-mode reads starting near column 527 reach the page-boundary turnover quickly. A main-mode read from column 254 crosses the same boundary through the full second half of a page.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_STREAM = 2'd2
  } rd_state_e;

  typedef enum logic {
    AREA_MAIN  = 1'b0,
    AREA_SPARE = 1'b1
  } rd_area_e;

  localparam logic [7:0] CMD_RD_MAIN  = 8'h00;
  localparam logic [7:0] CMD_RD_HALF  = 8'h01;
  localparam logic [7:0] CMD_RD_SPARE = 8'h50;

  // Fixed cell contents: a pure function of page and column.
  function automatic logic [7:0] cell_byte(input logic [15:0] page,
                                           input logic [15:0] col);
    return col[7:0] ^ {page[5:0], col[9:8]};
  endfunction

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io_in,
  output logic       cmd_wr,
  output logic       addr_wr,
  output logic       re_fall,
  output logic       ce_off,
  output logic [7:0] io_q
);

  logic s_cle, s_ale, s_we, s_we_d, s_re, s_re_d, s_ce;
  logic we_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cle  <= 1'b0;
      s_ale  <= 1'b0;
      s_we   <= 1'b1;
      s_we_d <= 1'b1;
      s_re   <= 1'b1;
      s_re_d <= 1'b1;
      s_ce   <= 1'b1;
      io_q   <= 8'h00;
    end else begin
      s_cle  <= cle;
      s_ale  <= ale;
      s_we   <= we_n;
      s_we_d <= s_we;
      s_re   <= re_n;
      s_re_d <= s_re;
      s_ce   <= ce_n;
      io_q   <= io_in;
    end
  end

  assign we_rise = s_we & ~s_we_d & ~s_ce;
  assign cmd_wr  = we_rise & s_cle & ~s_ale;
  assign addr_wr = we_rise & s_ale & ~s_cle;
  assign re_fall = s_re_d & ~s_re;
  assign ce_off  = s_ce;

endmodule

// File: rtl/nand_page_rom.sv
module nand_page_rom #(
  parameter int PAGE_AW = 5,
  parameter int COL_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [PAGE_AW-1:0] rd_page,
  input  logic [COL_W-1:0]   rd_col,
  output logic [7:0]         rd_data
);
  import nand_rd_pkg::*;

  logic [7:0] data_nxt;

  assign data_nxt = cell_byte(16'(rd_page), 16'(rd_col));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= 8'h00;
    end else if (rd_en) begin
      rd_data <= data_nxt;
    end
  end

endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq #(
  parameter int PAGE_AW     = 5,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int TR_CYCLES   = 20,
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int SPW        = $clog2(SPARE_BYTES),
  localparam int TCW        = $clog2(TR_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic               addr_wr,
  input  logic               re_fall,
  input  logic               ce_off,
  input  logic [7:0]         io_q,
  output logic               rom_en,
  output logic [PAGE_AW-1:0] rom_page,
  output logic [COL_W-1:0]   rom_col,
  output logic               rb_n
);
  import nand_rd_pkg::*;

  localparam logic [COL_W-1:0] LAST_COL   = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);
  localparam logic [COL_W-1:0] HALF_BASE  = COL_W'(MAIN_BYTES / 2);
  localparam logic [TCW-1:0]   TR_LAST    = TCW'(TR_CYCLES - 1);

  rd_state_e          state, state_nxt;
  rd_area_e           area, area_nxt;
  logic               half, half_nxt;
  logic [1:0]         acnt, acnt_nxt;
  logic [7:0]         colb, colb_nxt;
  logic [7:0]         plo, plo_nxt;
  logic [PAGE_AW-1:0] page, page_nxt;
  logic [COL_W-1:0]   col, col_nxt;
  logic [TCW-1:0]     tcnt, tcnt_nxt;
  logic [COL_W-1:0]   start_col;
  logic [COL_W-1:0]   wrap_col;

  always_comb begin
    if (area == AREA_SPARE) begin
      start_col = SPARE_BASE + COL_W'(colb[SPW-1:0]);
      wrap_col  = SPARE_BASE;
    end else begin
      start_col = (half ? HALF_BASE : '0) + COL_W'(colb);
      wrap_col  = '0;
    end
  end

  always_comb begin
    state_nxt = state;
    area_nxt  = area;
    half_nxt  = half;
    acnt_nxt  = acnt;
    colb_nxt  = colb;
    plo_nxt   = plo;
    page_nxt  = page;
    col_nxt   = col;
    tcnt_nxt  = tcnt;
    rom_en    = 1'b0;
    case (state)
      ST_BUSY: begin
        if (ce_off) begin
          state_nxt = ST_IDLE;
        end else if (tcnt == TR_LAST) begin
          state_nxt = ST_STREAM;
          tcnt_nxt  = '0;
        end else begin
          tcnt_nxt = tcnt + TCW'(1);
        end
      end
      default: begin
        if (ce_off) begin
          state_nxt = ST_IDLE;
        end else if (cmd_wr) begin
          case (io_q)
            CMD_RD_MAIN: begin
              area_nxt = AREA_MAIN; half_nxt = 1'b0;
              acnt_nxt = 2'd0; state_nxt = ST_IDLE;
            end
            CMD_RD_HALF: begin
              area_nxt = AREA_MAIN; half_nxt = 1'b1;
              acnt_nxt = 2'd0; state_nxt = ST_IDLE;
            end
            CMD_RD_SPARE: begin
              area_nxt = AREA_SPARE;
              acnt_nxt = 2'd0; state_nxt = ST_IDLE;
            end
            default: ;
          endcase
        end else if (addr_wr) begin
          case (acnt)
            2'd0: begin colb_nxt = io_q; acnt_nxt = 2'd1; end
            2'd1: begin plo_nxt = io_q; acnt_nxt = 2'd2; end
            default: begin
              page_nxt  = PAGE_AW'({io_q, plo});
              col_nxt   = start_col;
              acnt_nxt  = 2'd0;
              state_nxt = ST_BUSY;
              tcnt_nxt  = '0;
            end
          endcase
        end else if (re_fall && state == ST_STREAM) begin
          rom_en = 1'b1;
          if (col == LAST_COL) begin
            page_nxt  = page + PAGE_AW'(1);
            col_nxt   = wrap_col;
            state_nxt = ST_BUSY;
            tcnt_nxt  = '0;
          end else begin
            col_nxt = col + COL_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      area  <= AREA_MAIN;
      half  <= 1'b0;
      acnt  <= 2'd0;
      colb  <= 8'h00;
      plo   <= 8'h00;
      page  <= '0;
      col   <= '0;
      tcnt  <= '0;
    end else begin
      state <= state_nxt;
      area  <= area_nxt;
      half  <= half_nxt;
      acnt  <= acnt_nxt;
      colb  <= colb_nxt;
      plo   <= plo_nxt;
      page  <= page_nxt;
      col   <= col_nxt;
      tcnt  <= tcnt_nxt;
    end
  end

  assign rom_page = page;
  assign rom_col  = col;
  assign rb_n     = (state != ST_BUSY);

endmodule

// File: rtl/nand_rdptr_ctrl.sv
module nand_rdptr_ctrl #(
  parameter int PAGE_AW     = 5,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int TR_CYCLES   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       rb_n
);
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int COL_W      = $clog2(PAGE_BYTES);

  logic               cmd_wr, addr_wr, re_fall, ce_off;
  logic [7:0]         io_q;
  logic               rom_en;
  logic [PAGE_AW-1:0] rom_page;
  logic [COL_W-1:0]   rom_col;

  nand_bus_sampler u_smp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .cle     (cle),
    .ale     (ale),
    .we_n    (we_n),
    .re_n    (re_n),
    .io_in   (io_in),
    .cmd_wr  (cmd_wr),
    .addr_wr (addr_wr),
    .re_fall (re_fall),
    .ce_off  (ce_off),
    .io_q    (io_q)
  );

  nand_read_seq #(
    .PAGE_AW     (PAGE_AW),
    .MAIN_BYTES  (MAIN_BYTES),
    .SPARE_BYTES (SPARE_BYTES),
    .TR_CYCLES   (TR_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .addr_wr  (addr_wr),
    .re_fall  (re_fall),
    .ce_off   (ce_off),
    .io_q     (io_q),
    .rom_en   (rom_en),
    .rom_page (rom_page),
    .rom_col  (rom_col),
    .rb_n     (rb_n)
  );

  nand_page_rom #(
    .PAGE_AW (PAGE_AW),
    .COL_W   (COL_W)
  ) u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rom_en),
    .rd_page (rom_page),
    .rd_col  (rom_col),
    .rd_data (io_out)
  );

endmodule

// File: rtl/nand_rdptr_chk.sv
module nand_rdptr_chk #(
  parameter int TR_CYCLES = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rb_n,
  input logic [7:0] io_out,
  input logic       ce_off,
  input logic       re_fall,
  input logic       addr_wr
);

  logic [15:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= 16'd0;
    end else if (!rb_n) begin
      busy_len <= busy_len + 16'd1;
    end else begin
      busy_len <= 16'd0;
    end
  end

  // R2
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= 16'(TR_CYCLES));

  // R6
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_n) |-> ($past(addr_wr) || $past(re_fall)));

  // R9
  busy_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_n && re_fall) |=> $stable(io_out));

  // R7
  ce_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_off |=> rb_n);

  // R7
  ce_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_off && re_fall) |=> $stable(io_out));

endmodule

bind nand_rdptr_ctrl nand_rdptr_chk #(.TR_CYCLES(TR_CYCLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rb_n    (rb_n),
  .io_out  (io_out),
  .ce_off  (ce_off),
  .re_fall (re_fall),
  .addr_wr (addr_wr)
);

// File: tb/nand_rdptr_ctrl_bench.sv
module nand_rdptr_ctrl_bench;

  localparam int TR     = 6;
  localparam int PAW    = 2;
  localparam int NPAGES = 1 << PAW;

  logic       clk;
  logic       rst_n;
  logic       ce_n, cle, ale, we_n, re_n;
  logic [7:0] io_in;
  logic [7:0] io_out;
  logic       rb_n;

  int tests;
  int fails;
  bit done;

  // reference pointer state
  int  exp_page;
  int  exp_col;
  bit  exp_spare;
  bit  exp_half;

  nand_rdptr_ctrl #(.PAGE_AW(PAW), .TR_CYCLES(TR)) u_nand_rdptr_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .io_in(io_in), .io_out(io_out), .rb_n(rb_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] model_byte(input int p, input int c);
    logic [15:0] pc;
    logic [15:0] cc;
    pc = 16'(p);
    cc = 16'(c);
    return cc[7:0] ^ {pc[5:0], cc[9:8]};
  endfunction

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] v);
    @(negedge clk);
    cle = c; ale = a; io_in = v; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic command(input logic [7:0] c);
    wr(1'b1, 1'b0, c);
    if (c == 8'h00) begin exp_spare = 0; exp_half = 0; end
    if (c == 8'h01) begin exp_spare = 0; exp_half = 1; end
    if (c == 8'h50) exp_spare = 1;
  endtask

  task automatic address(input logic [7:0] cb, input logic [15:0] pg);
    wr(1'b0, 1'b1, cb);
    wr(1'b0, 1'b1, pg[7:0]);
    wr(1'b0, 1'b1, pg[15:8]);
    exp_page = int'(pg) % NPAGES;
    if (exp_spare) exp_col = 512 + int'(cb[3:0]);
    else           exp_col = (exp_half ? 256 : 0) + int'(cb);
  endtask

  // returns number of low cycles seen in the busy window
  task automatic wait_ready(output int cnt);
    bit seen;
    cnt = 0; seen = 0;
    for (int g = 0; g < TR + 20; g++) begin
      if (!rb_n) begin cnt++; seen = 1; end
      else if (seen) break;
      @(negedge clk);
    end
  endtask

  task automatic re_pulse();
    @(negedge clk);
    re_n = 1'b0;
    @(negedge clk);
    re_n = 1'b1;
    @(negedge clk);
  endtask

  // read one byte, compare with model, advance model; returns 1 on page turn
  task automatic read_byte(input string req, output bit turned);
    re_pulse();
    check(req, int'(io_out), int'(model_byte(exp_page, exp_col)));
    turned = 0;
    if (exp_col == 527) begin
      exp_page = (exp_page + 1) % NPAGES;
      exp_col  = exp_spare ? 512 : 0;
      turned   = 1;
    end else begin
      exp_col++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int  n;
    bit  t;
    int  bad;
    logic [7:0] held;
    tests = 0; fails = 0; done = 0;
    exp_page = 0; exp_col = 0; exp_spare = 0; exp_half = 0;
    rst_n = 1'b0; ce_n = 1'b1; cle = 1'b0; ale = 1'b0;
    we_n = 1'b1; re_n = 1'b1; io_in = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    @(negedge clk);

    // R1 reset state and read before any address
    check("R1 rb_n", int'(rb_n), 1);
    check("R1 io_out", int'(io_out), 0);
    re_pulse();
    check("R1 read ignored", int'(io_out), 0);

    // R2 / R3 main read
    command(8'h00);
    address(8'd5, 16'd1);
    wait_ready(n);
    check("R2 busy cycles", n, TR);
    check("R2 ready", int'(rb_n), 1);
    for (int i = 0; i < 4; i++) read_byte("R3", t);

    // R4 second half of main area
    command(8'h01);
    address(8'd10, 16'd2);
    check("R4 start col", exp_col, 266);
    wait_ready(n);
    for (int i = 0; i < 3; i++) read_byte("R4", t);

    // R5 spare area, upper nibble ignored, then R6 wrap to page 0
    command(8'h50);
    address(8'hF3, 16'd3);
    wait_ready(n);
    read_byte("R5 first spare", t);
    check("R5 col after first", exp_col, 516);
    for (int i = 0; i < 12; i++) read_byte("R5", t);
    check("R6 page turned", int'(t), 1);
    check("R6 wrap page", exp_page, 0);
    wait_ready(n);
    check("R6 busy cycles", n, TR);
    read_byte("R6 spare of next page", t);
    read_byte("R6", t);

    // R8 no new command: spare mode reused; R9 read during busy
    held = io_out;
    address(8'h07, 16'd1);
    re_pulse();
    check("R9 busy read ignored", int'(io_out), int'(held));
    wait_ready(n);
    read_byte("R8 spare reused", t);

    // R10 unknown command leaves pointer
    command(8'h90);
    address(8'h02, 16'd2);
    wait_ready(n);
    read_byte("R10 still spare", t);

    // R8 only a main read command returns pointer
    command(8'h00);
    address(8'h00, 16'd0);
    wait_ready(n);
    read_byte("R8 back to main", t);
    read_byte("R8", t);

    // R7 chip enable high ends stream
    held = io_out;
    @(negedge clk);
    ce_n = 1'b1;
    re_pulse();
    check("R7 stream ended", int'(io_out), int'(held));
    check("R7 ready", int'(rb_n), 1);
    @(negedge clk);
    ce_n = 1'b0;
    re_pulse();
    check("R7 stays ended", int'(io_out), int'(held));

    // R7 abort during busy
    address(8'h00, 16'd1);
    @(negedge clk);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 busy aborted", int'(rb_n), 1);
    re_pulse();
    check("R7 abort no data", int'(io_out), int'(held));
    ce_n = 1'b0;
    @(negedge clk);

    // R3 / R6 long main read across page end with wrap
    command(8'h00);
    address(8'd254, 16'd3);
    wait_ready(n);
    bad = 0;
    for (int i = 0; i < 274; i++) begin
      re_pulse();
      if (io_out != model_byte(exp_page, exp_col)) bad++;
      exp_col++;
    end
    check("R3 long stream mismatches", bad, 0);
    check("R6 busy after 527", int'(rb_n), 0);
    exp_page = 0; exp_col = 0;
    wait_ready(n);
    check("R6 main busy cycles", n, TR);
    read_byte("R6 main col 0 of page 0", t);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule